// File: doc/BRIEF.md
# VID Soft-Transient Stepper

This block sits between the processor's 7-bit voltage-identification bus and the DAC of a core-voltage regulator. It turns the code on the bus into an internal target code. Each step of the target code moves the regulator by one VID step of 12.5 mV. Code 0 is the highest voltage, and each increment of the code lowers the voltage by one step. The block also drives a power-good mask, so that a planned voltage move is never reported as a regulation fault.

A change on the bus first has to survive a skew window. Bits that arrive at slightly different times are never acted on. Once a code is accepted, the internal target walks one code at a time toward it, and it never jumps. The step interval is 4 µs (slow) or 1 µs (fast). The interval depends on the direction of the move, the deeper-sleep input and a boot-transition flag. The regulator's power-good logic should be gated with the mask. Every bus change starts the mask, and every internal step extends it by 100 µs.

Top module: `vid_slew_stepper`

## Requirements
- R1: After reset the target code equals the parameter RESET_CODE (default 40), the busy flag is low and the mask is low.
- R2: A bus change is acted on only after the bus has been stable for DEG_CYC cycles (at least 400 ns). Any change within that window restarts it. A code that returns to the current value before the window ends causes no step.
- R3: Every update of the target code changes it by exactly one, toward the accepted code, until the two are equal.
- R4: The first update comes one step interval after acceptance, which is DEG_CYC + interval + 2 clock edges after the edge that first sees the change. Later updates follow one interval apart.
- R5: A move to a lower code (rising voltage) with the sleep input low and the boot flag low steps every 1 µs (FAST_CYC cycles).
- R6: A move to a lower code with the sleep input high and the boot flag low steps every 4 µs (SLOW_CYC cycles).
- R7: A move to a higher code (falling voltage) steps every 4 µs, whatever the sleep input is.
- R8: With the boot flag high, both directions step every 4 µs, and the sleep input has no effect.
- R9: A code accepted in the middle of a transition redirects the stepping from the current internal code. The rate is chosen again from the new direction and the inputs.
- R10: The busy flag is high exactly while the internal code differs from the accepted code.
- R11: The mask rises within two cycles of any bus change. It falls MASK_CYC + 1 cycles (100 µs) after the last internal update, or after the last change when no update follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_i | input | 7 | Voltage-identification code from the processor |
| sleep_i | input | 1 | Deeper-sleep mode input, sampled when a code is accepted |
| boot_i | input | 1 | High while moving from the boot voltage to the first code |
| target_o | output | 7 | Internal target code driven to the DAC |
| busy_o | output | 1 | Internal code has not yet reached the accepted code |
| pgmask_o | output | 1 | Power-good mask |

## Verification
The assertions assume that the bus is synchronous to the block clock and that the step intervals are far shorter than the mask length. Under that assumption, busy can only occur while the mask is up. Without it, a target could sit unchanged for longer than the mask. The bench changes the bus only at falling clock edges and keeps the default timing parameters. It waits for the mask to drop before each new scenario, so every expected delay is counted from a quiet start.

// File: rtl/vid_pkg.sv
package vid_pkg;

    localparam int VID_W = 7;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // One code toward the goal; equal codes stay put.
    function automatic logic [VID_W-1:0] step_toward(
        input logic [VID_W-1:0] cur,
        input logic [VID_W-1:0] goal
    );
        if (goal > cur)
            return cur + VID_W'(1);
        else if (goal < cur)
            return cur - VID_W'(1);
        else
            return cur;
    endfunction

endpackage

// File: rtl/vid_deglitch.sv
module vid_deglitch #(
    parameter int               VID_W      = 7,
    parameter int               DEG_CYC    = 50,
    parameter logic [VID_W-1:0] RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid_i,
    output logic             chg_o,
    output logic             acc_o,
    output logic [VID_W-1:0] acc_code_o
);
    localparam int CW = $clog2(DEG_CYC + 1);

    typedef struct packed {
        logic [VID_W-1:0] last;
        logic [CW-1:0]    cnt;
        logic             pend;
        logic             chg;
        logic             acc;
        logic [VID_W-1:0] code;
    } dg_state_t;

    dg_state_t q, d;

    always_comb begin
        d     = q;
        d.chg = 1'b0;
        d.acc = 1'b0;
        if (vid_i != q.last) begin
            // any movement restarts the skew window
            d.last = vid_i;
            d.cnt  = CW'(DEG_CYC);
            d.pend = 1'b1;
            d.chg  = 1'b1;
        end else if (q.pend) begin
            if (q.cnt <= CW'(1)) begin
                d.acc  = 1'b1;
                d.code = q.last;
                d.pend = 1'b0;
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.last <= RESET_CODE;
            q.cnt  <= '0;
            q.pend <= 1'b0;
            q.chg  <= 1'b0;
            q.acc  <= 1'b0;
            q.code <= RESET_CODE;
        end else begin
            q <= d;
        end
    end

    assign chg_o      = q.chg;
    assign acc_o      = q.acc;
    assign acc_code_o = q.code;

endmodule

// File: rtl/vid_step_engine.sv
module vid_step_engine
    import vid_pkg::*;
#(
    parameter int               VID_W      = 7,
    parameter int               SLOW_CYC   = 500,
    parameter int               FAST_CYC   = 125,
    parameter logic [VID_W-1:0] RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic [VID_W-1:0] acc_code_i,
    input  logic             sleep_i,
    input  logic             boot_i,
    output logic [VID_W-1:0] cur_o,
    output logic             busy_o,
    output logic             step_o
);
    localparam int MAXC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic [VID_W-1:0] cur;
        logic [VID_W-1:0] tgt;
        rate_e            rate;
        logic [TW-1:0]    tmr;
        logic             step;
    } st_state_t;

    st_state_t q, d;
    rate_e     new_rate;

    // Rate for a freshly accepted code: boot, then direction, then sleep.
    always_comb begin
        if (boot_i)
            new_rate = RATE_SLOW;
        else if (acc_code_i < q.cur)
            new_rate = sleep_i ? RATE_SLOW : RATE_FAST;
        else
            new_rate = RATE_SLOW;
    end

    always_comb begin
        d      = q;
        d.step = 1'b0;
        if (acc_i) begin
            d.tgt  = acc_code_i;
            d.rate = new_rate;
            d.tmr  = (new_rate == RATE_FAST) ? TW'(FAST_CYC) : TW'(SLOW_CYC);
        end else if (q.cur != q.tgt) begin
            if (q.tmr <= TW'(1)) begin
                d.cur  = step_toward(q.cur, q.tgt);
                d.step = 1'b1;
                d.tmr  = (q.rate == RATE_FAST) ? TW'(FAST_CYC) : TW'(SLOW_CYC);
            end else begin
                d.tmr = q.tmr - TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cur  <= RESET_CODE;
            q.tgt  <= RESET_CODE;
            q.rate <= RATE_SLOW;
            q.tmr  <= '0;
            q.step <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cur_o  = q.cur;
    assign busy_o = (q.cur != q.tgt);
    assign step_o = q.step;

endmodule

// File: rtl/pg_mask_timer.sv
module pg_mask_timer #(
    parameter int MASK_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic step_i,
    output logic mask_o
);
    localparam int MW = $clog2(MASK_CYC + 1);

    typedef struct packed {
        logic [MW-1:0] cnt;
    } mk_state_t;

    mk_state_t q, d;

    always_comb begin
        d = q;
        if (chg_i || step_i)
            d.cnt = MW'(MASK_CYC);
        else if (q.cnt != '0)
            d.cnt = q.cnt - MW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q.cnt <= '0;
        else
            q <= d;
    end

    assign mask_o = (q.cnt != '0);

endmodule

// File: rtl/vid_slew_stepper.sv
module vid_slew_stepper #(
    parameter int               VID_W        = 7,
    parameter int               CLK_MHZ      = 125,
    parameter int               DEGLITCH_NS  = 400,
    parameter int               SLOW_STEP_NS = 4000,
    parameter int               FAST_STEP_NS = 1000,
    parameter int               MASK_NS      = 100000,
    parameter logic [VID_W-1:0] RESET_CODE   = 7'd40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid_i,
    input  logic             sleep_i,
    input  logic             boot_i,
    output logic [VID_W-1:0] target_o,
    output logic             busy_o,
    output logic             pgmask_o
);
    localparam int DEG_CYC  = (CLK_MHZ * DEGLITCH_NS + 999) / 1000;
    localparam int SLOW_CYC = (CLK_MHZ * SLOW_STEP_NS + 999) / 1000;
    localparam int FAST_CYC = (CLK_MHZ * FAST_STEP_NS + 999) / 1000;
    localparam int MASK_CYC = (CLK_MHZ * MASK_NS + 999) / 1000;

    logic             chg_w;
    logic             acc_w;
    logic [VID_W-1:0] acc_code_w;
    logic             step_w;

    vid_deglitch #(
        .VID_W      (VID_W),
        .DEG_CYC    (DEG_CYC),
        .RESET_CODE (RESET_CODE)
    ) u_dg (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_i      (vid_i),
        .chg_o      (chg_w),
        .acc_o      (acc_w),
        .acc_code_o (acc_code_w)
    );

    vid_step_engine #(
        .VID_W      (VID_W),
        .SLOW_CYC   (SLOW_CYC),
        .FAST_CYC   (FAST_CYC),
        .RESET_CODE (RESET_CODE)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (acc_w),
        .acc_code_i (acc_code_w),
        .sleep_i    (sleep_i),
        .boot_i     (boot_i),
        .cur_o      (target_o),
        .busy_o     (busy_o),
        .step_o     (step_w)
    );

    pg_mask_timer #(
        .MASK_CYC (MASK_CYC)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg_i  (chg_w),
        .step_i (step_w),
        .mask_o (pgmask_o)
    );

endmodule

// File: rtl/vid_slew_checker.sv
module vid_slew_checker #(
    parameter int VID_W    = 7,
    parameter int FAST_CYC = 125
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VID_W-1:0] vid_i,
    input logic [VID_W-1:0] target_o,
    input logic             busy_o,
    input logic             pgmask_o
);
    localparam int GW = $clog2(FAST_CYC + 2);

    logic [VID_W-1:0] last_q;
    logic [GW-1:0]    gap_q;
    logic             moved_w;

    assign moved_w = (target_o != last_q);

    // cycles since the target last moved, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= target_o;
            gap_q  <= GW'(FAST_CYC);
        end else begin
            last_q <= target_o;
            if (moved_w)
                gap_q <= GW'(1);
            else if (gap_q < GW'(FAST_CYC))
                gap_q <= gap_q + GW'(1);
        end
    end

    p_one_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (target_o != $past(target_o)) |->
            ((VID_W'(target_o - $past(target_o)) == VID_W'(1)) ||
             (VID_W'($past(target_o) - target_o) == VID_W'(1))));

    p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        moved_w |-> (gap_q >= GW'(FAST_CYC)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(target_o));

    p_busy_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> pgmask_o);

    p_change_masks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_i != $past(vid_i)) |-> ##2 pgmask_o);

endmodule

bind vid_slew_stepper vid_slew_checker #(
    .VID_W    (VID_W),
    .FAST_CYC (FAST_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_i    (vid_i),
    .target_o (target_o),
    .busy_o   (busy_o),
    .pgmask_o (pgmask_o)
);

// File: tb/tb_vid_slew_stepper.sv
module tb_vid_slew_stepper;

    localparam int DEG  = 50;
    localparam int SLOW = 500;
    localparam int FAST = 125;
    localparam int MASK = 12500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] vid_i = 7'd40;
    logic       sleep_i = 1'b0;
    logic       boot_i = 1'b0;
    logic [6:0] target_o;
    logic       busy_o;
    logic       pgmask_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vid_slew_stepper dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_i    (vid_i),
        .sleep_i  (sleep_i),
        .boot_i   (boot_i),
        .target_o (target_o),
        .busy_o   (busy_o),
        .pgmask_o (pgmask_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // count posedges until the target moves, then check delay and value
    task automatic wait_step(input int exp_n, input logic [6:0] exp_code,
                             input string req);
        logic [6:0] old;
        int n;
        old = target_o;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (target_o == old && n < 4000);
        check(n == exp_n, req, "step delay", n, exp_n);
        check(target_o == exp_code, req, "step code", target_o, exp_code);
    endtask

    task automatic wait_mask_low(input int exp_n, input string req);
        int n;
        n = 0;
        while (pgmask_o && n < 20000) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        if (exp_n >= 0)
            check(n == exp_n, req, "mask hold", n, exp_n);
    endtask

    task automatic t_reset();
        check(target_o == 7'd40, "R1", "reset target", target_o, 40);
        check(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        check(pgmask_o == 1'b0, "R1", "reset mask", pgmask_o, 0);
    endtask

    task automatic t_glitch();
        bit moved;
        bit busy_seen;
        moved = 1'b0;
        busy_seen = 1'b0;
        vid_i = 7'd41;
        repeat (20) @(negedge clk);
        vid_i = 7'd40;
        repeat (10) @(negedge clk);
        check(pgmask_o == 1'b1, "R11", "mask after change", pgmask_o, 1);
        for (int i = 0; i < DEG + SLOW + 20; i++) begin
            @(negedge clk);
            if (target_o != 7'd40) moved = 1'b1;
            if (busy_o) busy_seen = 1'b1;
        end
        check(!moved, "R2", "glitch moved target", target_o, 40);
        check(!busy_seen, "R10", "busy during glitch", busy_seen, 0);
        wait_mask_low(-1, "R11");
    endtask

    task automatic t_fast_exit();
        sleep_i = 1'b0;
        vid_i = 7'd37;
        wait_step(DEG + FAST + 2, 7'd39, "R5");
        check(busy_o == 1'b1, "R10", "busy mid transition", busy_o, 1);
        wait_step(FAST, 7'd38, "R5");
        wait_step(FAST, 7'd37, "R3");
        check(busy_o == 1'b0, "R10", "busy at goal", busy_o, 0);
        wait_mask_low(MASK + 1, "R11");
    endtask

    task automatic t_slow_exit();
        sleep_i = 1'b1;
        vid_i = 7'd35;
        wait_step(DEG + SLOW + 2, 7'd36, "R6");
        wait_step(SLOW, 7'd35, "R6");
        wait_mask_low(MASK + 1, "R11");
    endtask

    task automatic t_enter_sleep();
        sleep_i = 1'b1;
        vid_i = 7'd37;
        wait_step(DEG + SLOW + 2, 7'd36, "R7");
        wait_step(SLOW, 7'd37, "R7");
        wait_mask_low(MASK + 1, "R11");
        sleep_i = 1'b0;
        vid_i = 7'd38;
        wait_step(DEG + SLOW + 2, 7'd38, "R7");
        wait_mask_low(MASK + 1, "R11");
    endtask

    task automatic t_boot();
        boot_i = 1'b1;
        sleep_i = 1'b0;
        vid_i = 7'd36;
        wait_step(DEG + SLOW + 2, 7'd37, "R8");
        wait_step(SLOW, 7'd36, "R8");
        check(busy_o == 1'b0, "R10", "busy after boot move", busy_o, 0);
        wait_mask_low(MASK + 1, "R11");
        boot_i = 1'b0;
    endtask

    task automatic t_restart_window();
        sleep_i = 1'b0;
        vid_i = 7'd41;
        repeat (30) @(negedge clk);
        vid_i = 7'd34;
        wait_step(DEG + FAST + 2, 7'd35, "R2");
        wait_step(FAST, 7'd34, "R4");
        wait_mask_low(MASK + 1, "R11");
    endtask

    task automatic t_retarget();
        sleep_i = 1'b0;
        vid_i = 7'd30;
        wait_step(DEG + FAST + 2, 7'd33, "R9");
        wait_step(FAST, 7'd32, "R9");
        vid_i = 7'd33;
        wait_step(DEG + SLOW + 2, 7'd33, "R9");
        check(busy_o == 1'b0, "R9", "busy after redirect", busy_o, 0);
        wait_mask_low(MASK + 1, "R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_glitch();
        t_fast_exit();
        t_slow_exit();
        t_enter_sleep();
        t_boot();
        t_restart_window();
        t_retarget();
        summary();
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

endmodule